// File: doc/BRIEF.md
# Backlight PWM Generator

This block produces a pulse-width-modulated signal for dimming a display backlight. Software programs it through a byte-wide write/read strobe interface. An 8-bit prescaler stretches each step of a 16-bit step counter. The period length is the scale value, and a 16-bit brightness value sets how many steps are active. Two control bits gate the signal: one enables it and one inverts its polarity.

The generated signal leaves the block on the fourth of four general-purpose pins, and only when that pin's 2-bit function field selects the special function. The other field codes turn a pin into a plain input or into an output driven from a data register.

Timing settings are written into staging registers and copied into the running counters only at a period boundary. A period that has already started therefore always completes with one consistent setting.

Top module: `bl_pwm_top`

## Requirements
- R1: One period lasts P*S+1 clock cycles, where S is the scale and P is the prescaler value, with a prescaler value of 0 treated as 1.
- R2: When 0 < B < S, where B is the brightness, the output is active for the first P*B cycles of each period and inactive for the rest.
- R3: A brightness of 0 keeps the output inactive for the whole period. A brightness with B >= S and B != 0 keeps it active for the whole period.
- R4: The control register at 0xA5 holds the enable in bit 1 and the invert in bit 0. While disabled, the output sits at its inactive level and all counters are cleared. After the enable is set, the first period starts in the cycle right after the enabling write.
- R5: The active level is high with invert = 0 and low with invert = 1.
- R6: The scale (0xA1 low, 0xA2 high) and brightness (0xA3 low, 0xA4 high) are written low byte first. A low-byte write alone leaves the readback unchanged. The high-byte write commits both bytes together.
- R7: New prescaler, scale or brightness values written while running take effect only at the next period start. The current period ends with the old values.
- R8: Register readback: 0xA0 prescaler, 0xA1..0xA4 the committed scale and brightness bytes, 0xA5 {6'b0, enable, invert}, 0x16 pin function fields, 0x17 {4'b0, data}. All read 0 after reset.
- R9: The pin function register at 0x16 gives pin i the field at bits [2i+1:2i]:
  - 2'b00 makes the pin an input (output enable 0, output 0).
  - 2'b01 drives the pin from bit i of the data register at 0x17.
  - 2'b10 on pin 3 routes the PWM signal.
  - Any other code makes the pin an input.
- R10: A read strobe returns data on rdata in the following cycle. Address 0x18 returns {4'b0, gpio_in}, and unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the PWM reference |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after rd_en |
| gpio_in | input | 4 | Pin input levels |
| gpio_out | output | 4 | Pin output levels |
| gpio_oe | output | 4 | Pin output enables |

## Verification
A wrong prescaler or step count shows on pin 3 as an edge one or more cycles away from P*B or P*S+1. This appears within the first period after enabling, and the bench compares that pin on every cycle. Shadow corruption, or a premature load of staged settings, moves an edge inside the period in which the write lands. A lost low byte or a wrong pin field shows up at once in register readback or in the pin enables.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    localparam int PRE_W   = 8;
    localparam int CNT_W   = 16;
    localparam int NPIN    = 4;
    localparam int PWM_PIN = 3;
    localparam int ADR_W   = 8;
    localparam int DAT_W   = 8;

    localparam logic [ADR_W-1:0] A_MUX   = 8'h16;
    localparam logic [ADR_W-1:0] A_DOUT  = 8'h17;
    localparam logic [ADR_W-1:0] A_PINS  = 8'h18;
    localparam logic [ADR_W-1:0] A_PRE   = 8'hA0;
    localparam logic [ADR_W-1:0] A_SCL_L = 8'hA1;
    localparam logic [ADR_W-1:0] A_SCL_H = 8'hA2;
    localparam logic [ADR_W-1:0] A_LVL_L = 8'hA3;
    localparam logic [ADR_W-1:0] A_LVL_H = 8'hA4;
    localparam logic [ADR_W-1:0] A_CTRL  = 8'hA5;

    typedef enum logic [1:0] {
        FN_INPUT  = 2'b00,
        FN_OUTPUT = 2'b01,
        FN_SPEC   = 2'b10,
        FN_RSVD   = 2'b11
    } pin_fn_e;

    typedef struct packed {
        logic [PRE_W-1:0] prediv;
        logic [CNT_W-1:0] scale;
        logic [CNT_W-1:0] level;
    } pwm_cfg_t;

    typedef struct packed {
        logic enable;   // bit 1 of control register
        logic invert;   // bit 0 of control register
    } pwm_ctrl_t;

    function automatic logic [PRE_W-1:0] eff_prediv(input logic [PRE_W-1:0] p);
        return (p == '0) ? PRE_W'(1) : p;
    endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADR_W-1:0]    addr,
    input  logic [DAT_W-1:0]    wdata,
    input  logic [NPIN-1:0]     pin_in,
    output logic [DAT_W-1:0]    rdata,
    output pwm_cfg_t            cfg_stg,
    output pwm_ctrl_t           ctrl,
    output logic [2*NPIN-1:0]   fn_sel,
    output logic [NPIN-1:0]     dout
);
    logic [7:0]       scl_lo, lvl_lo;
    logic [DAT_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_stg <= '0;
            ctrl    <= '0;
            fn_sel  <= '0;
            dout    <= '0;
            scl_lo  <= '0;
            lvl_lo  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_PRE:   cfg_stg.prediv <= wdata;
                A_SCL_L: scl_lo <= wdata;
                A_SCL_H: cfg_stg.scale <= {wdata, scl_lo};
                A_LVL_L: lvl_lo <= wdata;
                A_LVL_H: cfg_stg.level <= {wdata, lvl_lo};
                A_CTRL:  ctrl <= pwm_ctrl_t'(wdata[1:0]);
                A_MUX:   fn_sel <= wdata;
                A_DOUT:  dout <= wdata[NPIN-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_PRE:   rd_mux = cfg_stg.prediv;
            A_SCL_L: rd_mux = cfg_stg.scale[7:0];
            A_SCL_H: rd_mux = cfg_stg.scale[15:8];
            A_LVL_L: rd_mux = cfg_stg.level[7:0];
            A_LVL_H: rd_mux = cfg_stg.level[15:8];
            A_CTRL:  rd_mux = {6'b0, ctrl};
            A_MUX:   rd_mux = fn_sel;
            A_DOUT:  rd_mux = {{(DAT_W-NPIN){1'b0}}, dout};
            A_PINS:  rd_mux = {{(DAT_W-NPIN){1'b0}}, pin_in};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_LO_ONLY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SCL_L) |=> $stable(cfg_stg.scale)) else $error("lo"); // R6
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pwm_cfg_t  cfg_stg,
    input  pwm_ctrl_t ctrl,
    output logic      pwm_on
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    pwm_cfg_t         act;
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] step_cnt;
    logic             in_tail;
    logic [PRE_W-1:0] pre_lim;
    logic             lvl_on;

    assign pre_lim = eff_prediv(act.prediv) - PRE_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !ctrl.enable || in_tail) begin
            act      <= cfg_stg;               // shadow load only at period start
            pre_cnt  <= '0;
            step_cnt <= '0;
            in_tail  <= (cfg_stg.scale == '0);
        end else if (pre_cnt == pre_lim) begin
            pre_cnt <= '0;
            if (step_cnt == act.scale - ONE_C) in_tail <= 1'b1;
            else                               step_cnt <= step_cnt + ONE_C;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    always_comb begin
        if (act.level == '0)              lvl_on = 1'b0;
        else if (act.level >= act.scale)  lvl_on = 1'b1;
        else                              lvl_on = !in_tail && (step_cnt < act.level);
    end

    assign pwm_on = ctrl.enable & lvl_on;

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        ctrl.enable |-> pre_cnt <= pre_lim) else $error("pre"); // R1
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !in_tail) |-> step_cnt < act.scale) else $error("step"); // R1
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !in_tail) |=> $stable(act)) else $error("shadow"); // R7
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> (pre_cnt == '0 && step_cnt == '0)) else $error("idle"); // R4
endmodule

// File: rtl/bl_pwm_pinmux.sv
module bl_pwm_pinmux
    import bl_pwm_pkg::*;
(
    input  logic [2*NPIN-1:0] fn_sel,
    input  logic [NPIN-1:0]   dout,
    input  logic              pwm_pin,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pin_fn_e fn;
        logic    spec_lvl;
        assign fn = pin_fn_e'(fn_sel[2*i +: 2]);
        if (i == PWM_PIN) begin : g_pwm
            assign spec_lvl = pwm_pin;
        end else begin : g_plain
            assign spec_lvl = 1'b0;
        end
        always_comb begin
            pin_oe[i]  = 1'b0;
            pin_out[i] = 1'b0;
            case (fn)
                FN_OUTPUT: begin
                    pin_oe[i]  = 1'b1;
                    pin_out[i] = dout[i];
                end
                FN_SPEC: begin
                    pin_oe[i]  = (i == PWM_PIN);
                    pin_out[i] = spec_lvl;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [3:0]       gpio_in,
    output logic [3:0]       gpio_out,
    output logic [3:0]       gpio_oe
);
    pwm_cfg_t          cfg_stg;
    pwm_ctrl_t         ctrl;
    logic [2*NPIN-1:0] fn_sel;
    logic [NPIN-1:0]   dout;
    logic              pwm_on;
    logic              pwm_pin;

    bl_pwm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .pin_in(gpio_in), .rdata(rdata), .cfg_stg(cfg_stg),
        .ctrl(ctrl), .fn_sel(fn_sel), .dout(dout)
    );

    bl_pwm_core u_core (
        .clk(clk), .rst(rst), .cfg_stg(cfg_stg), .ctrl(ctrl), .pwm_on(pwm_on)
    );

    assign pwm_pin = pwm_on ^ ctrl.invert;

    bl_pwm_pinmux u_mux (
        .fn_sel(fn_sel), .dout(dout), .pwm_pin(pwm_pin),
        .pin_out(gpio_out), .pin_oe(gpio_oe)
    );

    AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && fn_sel[2*PWM_PIN +: 2] == FN_SPEC)
            |-> (gpio_oe[PWM_PIN] && gpio_out[PWM_PIN] == ctrl.invert)) else $error("park"); // R4
    AST_SPEC_ONLY_PIN3: assert property (@(posedge clk) disable iff (rst)
        (fn_sel[1:0] == FN_SPEC) |-> !gpio_oe[0]) else $error("spec"); // R9
endmodule

// File: tb/sim_bl_pwm_top.sv
`timescale 1ns/1ps
module sim_bl_pwm_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic [3:0] gpio_in = 4'b0110;
    logic [3:0] gpio_out, gpio_oe;

    always #4 clk = ~clk;   // 125 MHz

    bl_pwm_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit chk_on = 0;
    string phase = "R9";
    logic [7:0] rd_smp;

    // bench model of the programmed state
    logic [7:0]  m_pre = 0;
    logic [15:0] m_scl = 0, m_lvl = 0;
    logic [7:0]  m_scl_lo = 0, m_lvl_lo = 0;
    logic        m_en = 0, m_inv = 0;
    logic [7:0]  m_fn = 0;
    logic [3:0]  m_dat = 0;
    logic [7:0]  c_pre = 0;
    logic [15:0] c_scl = 0, c_lvl = 0;
    int          pos = 0;

    function automatic int per_len();
        int p = (c_pre == 0) ? 1 : int'(c_pre);
        return p * int'(c_scl) + 1;
    endfunction

    function automatic logic exp_act();
        int p = (c_pre == 0) ? 1 : int'(c_pre);
        if (c_lvl == 0) return 1'b0;
        if (c_lvl >= c_scl) return 1'b1;
        return pos < p * int'(c_lvl);
    endfunction

    function automatic logic [1:0] exp_pin(int i);
        case (m_fn[2*i +: 2])
            2'b01: return {1'b1, m_dat[i]};
            2'b10: return (i == 3) ? {1'b1, m_inv ^ (m_en & exp_act())} : 2'b00;
            default: return 2'b00;
        endcase
    endfunction

    task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        rd_smp = rdata;
        if (chk_on) begin
            for (int i = 0; i < 4; i++) begin
                logic [1:0] e = exp_pin(i);
                n_vec++;
                if ({gpio_oe[i], gpio_out[i]} !== e) begin
                    n_bad++;
                    $display("FAIL %s pin%0d pos=%0d got oe/out=%b%b exp %b", phase, i, pos,
                             gpio_oe[i], gpio_out[i], e);
                end
            end
        end
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        if (!m_en) begin
            c_pre = m_pre; c_scl = m_scl; c_lvl = m_lvl; pos = 0;
        end else begin
            pos++;
            if (pos == per_len()) begin
                pos = 0; c_pre = m_pre; c_scl = m_scl; c_lvl = m_lvl;
            end
        end
        if (w) begin
            case (a)
                8'hA0: m_pre = d;
                8'hA1: m_scl_lo = d;
                8'hA2: m_scl = {d, m_scl_lo};
                8'hA3: m_lvl_lo = d;
                8'hA4: m_lvl = {d, m_lvl_lo};
                8'hA5: begin m_en = d[1]; m_inv = d[0]; end
                8'h16: m_fn = d;
                8'h17: m_dat = d[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        cyc(1'b0, 1'b1, a, 8'h00);
        cyc(1'b0, 1'b0, 8'h00, 8'h00);
        n_vec++;
        if (rd_smp !== e) begin
            n_bad++;
            $display("FAIL %s read 0x%02h got 0x%02h exp 0x%02h", tag, a, rd_smp, e);
        end
    endtask

    task automatic run_cfg(input logic [7:0] p, input logic [15:0] s, input logic [15:0] b,
                           input logic inv, input string tag);
        phase = tag;
        wr(8'hA5, {6'b0, 1'b0, inv});
        wr(8'hA0, p);
        wr(8'hA1, s[7:0]); wr(8'hA2, s[15:8]);
        wr(8'hA3, b[7:0]); wr(8'hA4, b[15:8]);
        wr(8'hA5, {6'b0, 1'b1, inv});
        idle(2 * per_len_of(p, s) + 3);
    endtask

    function automatic int per_len_of(logic [7:0] p, logic [15:0] s);
        return ((p == 0) ? 1 : int'(p)) * int'(s) + 1;
    endfunction

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk_on = 1;

        // R8 reset readback, R10 read latency and pin inputs
        rd_chk(8'hA0, 8'h00, "R8");
        rd_chk(8'hA2, 8'h00, "R8");
        rd_chk(8'hA5, 8'h00, "R8");
        rd_chk(8'h16, 8'h00, "R8");
        rd_chk(8'h18, {4'b0, gpio_in}, "R10");
        rd_chk(8'h55, 8'h00, "R10");

        // R6 low byte alone does not commit
        wr(8'hA1, 8'h34);
        rd_chk(8'hA1, 8'h00, "R6");
        wr(8'hA2, 8'h12);
        rd_chk(8'hA1, 8'h34, "R6");
        rd_chk(8'hA2, 8'h12, "R6");
        wr(8'hA3, 8'h9A);
        rd_chk(8'hA4, 8'h00, "R6");
        wr(8'hA4, 8'h05);
        rd_chk(8'hA3, 8'h9A, "R6");

        // R9 pin functions: pin0 out, pin1 in, pin2 special (not PWM), pin3 out
        phase = "R9";
        wr(8'h17, 8'h0A);
        wr(8'h16, 8'b01_10_00_01);
        idle(3);
        wr(8'h16, 8'b11_01_01_11);
        idle(3);
        rd_chk(8'h16, 8'b11_01_01_11, "R8");
        rd_chk(8'h17, 8'h0A, "R8");

        // R4 parking level while disabled, pin3 in PWM function
        phase = "R4 R5";
        wr(8'h16, 8'b10_00_00_00);
        wr(8'hA5, 8'h01);
        idle(4);
        wr(8'hA5, 8'h00);
        idle(4);
        rd_chk(8'hA5, 8'h00, "R8");

        // directed corners
        run_cfg(8'd0, 16'd6, 16'd2, 1'b0, "R1");      // prescaler 0 acts as 1
        run_cfg(8'd3, 16'd5, 16'd2, 1'b0, "R2");
        run_cfg(8'd2, 16'd7, 16'd0, 1'b0, "R3");
        run_cfg(8'd2, 16'd7, 16'd7, 1'b1, "R3");
        run_cfg(8'd2, 16'd4, 16'd9, 1'b0, "R3");
        run_cfg(8'd3, 16'd0, 16'd1, 1'b0, "R1");      // scale 0: one-cycle period
        run_cfg(8'd4, 16'd6, 16'd3, 1'b1, "R5");

        // R7 change brightness and scale mid-period
        run_cfg(8'd2, 16'd10, 16'd3, 1'b0, "R7");
        idle(5);
        wr(8'hA3, 8'd8); wr(8'hA4, 8'd0);
        idle(4);
        wr(8'hA0, 8'd1);
        wr(8'hA1, 8'd5); wr(8'hA2, 8'd0);
        idle(40);

        // R4 disable mid-period then re-enable restarts from period start
        phase = "R4";
        wr(8'hA5, 8'h00);
        idle(3);
        wr(8'hA5, 8'h02);
        idle(15);

        // random trials
        for (int t = 0; t < 24; t++) begin
            logic [7:0]  p = 8'($urandom_range(0, 3));
            logic [15:0] s = 16'($urandom_range(0, 20));
            logic [15:0] b = 16'($urandom_range(0, 24));
            run_cfg(p, s, b, 1'($urandom_range(0, 1)), "R2 R3");
        end

        // full-width scale
        phase = "R1";
        wr(8'hA5, 8'h00);
        wr(8'hA0, 8'd1);
        wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF);
        wr(8'hA3, 8'h00); wr(8'hA4, 8'h80);
        wr(8'hA5, 8'h02);
        idle(300);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule